// File: doc/BRIEF.md
# Signed 64-by-32 Division Peripheral

This block is a register-mapped arithmetic engine that divides a signed 64-bit dividend by a signed 32-bit divisor. Software loads the divisor and the two dividend halves through a small register bus, and a write to the low dividend word launches the operation. A second, narrower entry point accepts a single 32-bit dividend and widens it by copying its sign bit across the whole upper word, so a 32-by-32 divide costs one write.

Results return in place. The quotient replaces the low dividend word and the remainder replaces the upper one. An iterative engine retires one quotient bit per clock, and a busy output covers the whole run. A result that cannot be held in 32 signed bits, which includes division by zero, saturates the quotient and sets a sticky flag. The flag, gated by an enable bit, drives an interrupt request. A 7-bit vector register, which reset leaves untouched, travels with that request.

Top module: `sdiv_unit`

## Requirements
- R1: Writing the low dividend register (index 5) starts a signed division of {high register (index 4), low register} by the divisor register (index 0). Without overflow, the low register then holds the quotient rounded toward zero and the high register holds the remainder, whose sign matches the dividend.
- R2: Writing the short dividend register (index 1) loads the low register, sets all 32 bits of the high register to bit 31 of the new low value, and starts a division of that widened value. Reads of index 1 return the low register.
- R3: busy goes high in the cycle after the starting write and stays high for exactly 33 cycles. Reads during that time return the register contents from before the operation.
- R4: While busy is high, writes to indices 0, 1, 4 and 5 change nothing and start nothing.
- R5: A zero divisor or a quotient outside -2^31..2^31-1 is an overflow. The low register then gets 0x7FFFFFFF when dividend and divisor have equal signs (a zero divisor counts as positive), otherwise 0x80000000. The high register keeps its value and control bit 0 is set.
- R6: In the control register (index 2), bit 0 is the overflow flag and bit 1 is the interrupt enable, and irq equals flag AND enable. Writing 0 to bit 0 clears the flag and writing 1 leaves it as it is. An overflow that completes in the same cycle as a clear wins over the clear.
- R7: The vector register (index 3) keeps bits 6:0 of a write, reads as zero in bits 31:7, drives irq_vector, and is not changed by rst_n.
- R8: When bus_half is high, a write changes only bits 15:0 of the addressed register.
- R9: After rst_n, busy is low, irq is low and the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 16-bit write: only bits 15:0 are updated |
| bus_addr | input | 3 | Register index (0 divisor, 1 short dividend, 2 control, 3 vector, 4 high, 5 low) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| busy | output | 1 | Division in progress |
| irq | output | 1 | Overflow interrupt request |
| irq_vector | output | 7 | Vector number sent with irq |

## Verification
The hardest cases to reach are the boundaries of signed overflow. A quotient of exactly -2^31 must pass, the matching +2^31 must saturate, and an upper dividend word larger than the divisor must be caught before any iteration runs. The bench builds these from chosen multiples of 2^31 and from the most negative 64-bit dividend. It also writes the dividend, divisor and short registers in the middle of a run to show that those writes are dropped. A zero divisor sent through the short register leaves the high word untouched, so the sign fill can be seen at the ports.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ITER = 2'd1,
      ST_FIN  = 2'd2
   } sdiv_state_e;

   typedef enum logic [2:0] {
      RG_DIVISOR   = 3'd0,
      RG_DVD_SHORT = 3'd1,
      RG_CTRL      = 3'd2,
      RG_VECTOR    = 3'd3,
      RG_DVD_HIGH  = 3'd4,
      RG_DVD_LOW   = 3'd5
   } sdiv_reg_e;

   localparam int CTRL_FLAG_BIT = 0;
   localparam int CTRL_EN_BIT   = 1;

endpackage

// File: rtl/sdiv_step.sv
// One quotient bit per call: shift the partial remainder, then add or subtract.
module sdiv_step #(
   parameter int DW      = 32,
   parameter bit NONREST = 1'b1
) (
   input  logic [DW+1:0] rem_i,
   input  logic [DW-1:0] q_i,
   input  logic [DW-1:0] d_i,
   output logic [DW+1:0] rem_o,
   output logic [DW-1:0] q_o
);
   localparam int RW = DW + 2;

   logic [RW-1:0] sh_w;
   logic [RW-1:0] dd_w;
   logic          qbit_w;

   assign sh_w = {rem_i[DW:0], q_i[DW-1]};
   assign dd_w = {2'b00, d_i};

   generate
      if (NONREST) begin : g_nonrest
         // remainder may go negative; sign of the previous step picks the operation
         always_comb begin
            rem_o  = rem_i[RW-1] ? (sh_w + dd_w) : (sh_w - dd_w);
            qbit_w = ~rem_o[RW-1];
         end
      end else begin : g_restore
         logic ge_w;
         always_comb begin
            ge_w   = (sh_w >= dd_w);
            rem_o  = ge_w ? (sh_w - dd_w) : sh_w;
            qbit_w = ge_w;
         end
      end
   endgenerate

   assign q_o = {q_i[DW-2:0], qbit_w};

endmodule

// File: rtl/sdiv_core.sv
module sdiv_core
   import sdiv_pkg::*;
#(
   parameter int DW      = 32,
   parameter bit NONREST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] dvd_hi_i,
   input  logic [DW-1:0] dvd_lo_i,
   input  logic [DW-1:0] dvs_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [DW-1:0] quo_o,
   output logic [DW-1:0] rem_o,
   output logic          ovf_o
);
   localparam int CW = $clog2(DW);
   localparam int RW = DW + 2;
   localparam logic [DW-1:0] Q_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] Q_MIN = {1'b1, {(DW-1){1'b0}}};
   localparam logic [CW-1:0] LAST  = CW'(DW - 1);

   sdiv_state_e   st_q;
   logic [CW-1:0] cnt_q;
   logic [RW-1:0] rem_q, rem_nx;
   logic [DW-1:0] q_q, q_nx, d_q;
   logic          neg_q, dneg_q, pre_ovf_q;

   logic [2*DW-1:0] dvd_w, mag_w;
   logic [DW-1:0]   dmag_w;
   logic            pre_ovf_w;
   logic [RW-1:0]   rfix_w;
   logic [DW-1:0]   rmag_w;
   logic            post_ovf_w;

   // operand magnitudes and the early overflow test (quotient would need > DW bits)
   always_comb begin
      dvd_w     = {dvd_hi_i, dvd_lo_i};
      mag_w     = dvd_hi_i[DW-1] ? (~dvd_w + 1'b1) : dvd_w;
      dmag_w    = dvs_i[DW-1] ? (~dvs_i + 1'b1) : dvs_i;
      pre_ovf_w = (dvs_i == '0) || (mag_w[2*DW-1:DW] >= dmag_w);
   end

   sdiv_step #(.DW(DW), .NONREST(NONREST)) u_step (
      .rem_i (rem_q),
      .q_i   (q_q),
      .d_i   (d_q),
      .rem_o (rem_nx),
      .q_o   (q_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         rem_q     <= '0;
         q_q       <= '0;
         d_q       <= '0;
         neg_q     <= 1'b0;
         dneg_q    <= 1'b0;
         pre_ovf_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  rem_q     <= {2'b00, mag_w[2*DW-1:DW]};
                  q_q       <= mag_w[DW-1:0];
                  d_q       <= dmag_w;
                  neg_q     <= dvd_hi_i[DW-1] ^ dvs_i[DW-1];
                  dneg_q    <= dvd_hi_i[DW-1];
                  pre_ovf_q <= pre_ovf_w;
                  cnt_q     <= '0;
                  st_q      <= ST_ITER;
               end
            end
            ST_ITER: begin
               rem_q <= rem_nx;
               q_q   <= q_nx;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST) st_q <= ST_FIN;
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // final remainder correction and signed result formation
   always_comb begin
      rfix_w     = rem_q[RW-1] ? (rem_q + {2'b00, d_q}) : rem_q;
      rmag_w     = rfix_w[DW-1:0];
      post_ovf_w = neg_q ? (q_q[DW-1] && (|q_q[DW-2:0])) : q_q[DW-1];
      ovf_o      = pre_ovf_q | post_ovf_w;
      if (ovf_o)
         quo_o = neg_q ? Q_MIN : Q_MAX;
      else
         quo_o = neg_q ? (~q_q + 1'b1) : q_q;
      rem_o  = dneg_q ? (~rmag_w + 1'b1) : rmag_w;
      busy_o = (st_q != ST_IDLE);
      done_o = (st_q == ST_FIN);
   end

   // R3: once started the engine stays busy until the finish cycle
   a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);
   a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !done_o));
   // R5: an overflowing result is always one of the two saturation values
   a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ovf_o) |-> ((quo_o == Q_MAX) || (quo_o == Q_MIN)));
   // R1: corrected remainder lies in [0, |divisor|) when no early overflow
   a_r1_rem_range: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !pre_ovf_q) |-> ((rfix_w[RW-1:DW] == 2'b00) && (rmag_w < d_q)));

endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
   import sdiv_pkg::*;
#(
   parameter int DW      = 32,
   parameter int VEC_W   = 7,
   parameter bit NONREST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic             bus_half,
   input  logic [2:0]       bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   output logic             busy,
   output logic             irq,
   output logic [VEC_W-1:0] irq_vector
);
   localparam int HALF = DW / 2;

   generate
      if (DW < 8 || (DW % 2) != 0) begin : g_bad_dw
         $error("sdiv_unit: DW must be even and at least 8");
      end
      if (VEC_W < 1 || VEC_W > HALF) begin : g_bad_vec
         $error("sdiv_unit: VEC_W must lie in 1..DW/2");
      end
   endgenerate

   function automatic logic [DW-1:0] merge_w(input logic [DW-1:0] old_v,
                                             input logic [DW-1:0] new_v,
                                             input logic          half);
      return half ? {old_v[DW-1:HALF], new_v[HALF-1:0]} : new_v;
   endfunction

   logic [DW-1:0]    dvd_hi_q, dvd_lo_q, divisor_q;
   logic [VEC_W-1:0] vec_q;
   logic             flag_q, en_q;

   logic          wr_any, wr_data_ok, start;
   logic          hit_div, hit_short, hit_ctrl, hit_vec, hit_high, hit_low;
   logic [DW-1:0] lo_next, core_hi;
   logic          done, ovf;
   logic [DW-1:0] quo, rem;

   always_comb begin
      wr_any     = bus_sel & bus_wr;
      wr_data_ok = wr_any & ~busy;
      hit_div    = (bus_addr == RG_DIVISOR);
      hit_short  = (bus_addr == RG_DVD_SHORT);
      hit_ctrl   = (bus_addr == RG_CTRL);
      hit_vec    = (bus_addr == RG_VECTOR);
      hit_high   = (bus_addr == RG_DVD_HIGH);
      hit_low    = (bus_addr == RG_DVD_LOW);
      lo_next    = merge_w(dvd_lo_q, bus_wdata, bus_half);
      start      = wr_data_ok & (hit_short | hit_low);
      core_hi    = hit_short ? {DW{lo_next[DW-1]}} : dvd_hi_q;
   end

   sdiv_core #(.DW(DW), .NONREST(NONREST)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .dvd_hi_i (core_hi),
      .dvd_lo_i (lo_next),
      .dvs_i    (divisor_q),
      .busy_o   (busy),
      .done_o   (done),
      .quo_o    (quo),
      .rem_o    (rem),
      .ovf_o    (ovf)
   );

   // operand/result registers carry no reset: their contents are undefined after it
   always_ff @(posedge clk) begin
      if (done) begin
         dvd_lo_q <= quo;
         if (!ovf) dvd_hi_q <= rem;
      end else if (wr_data_ok) begin
         if (hit_div)              divisor_q <= merge_w(divisor_q, bus_wdata, bus_half);
         if (hit_high)             dvd_hi_q  <= merge_w(dvd_hi_q, bus_wdata, bus_half);
         if (hit_low || hit_short) dvd_lo_q  <= lo_next;
         if (hit_short)            dvd_hi_q  <= {DW{lo_next[DW-1]}};
      end
   end

   // vector number survives every reset
   always_ff @(posedge clk) begin
      if (wr_any && hit_vec) vec_q <= bus_wdata[VEC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         if (wr_any && hit_ctrl) begin
            en_q <= bus_wdata[CTRL_EN_BIT];
            if (!bus_wdata[CTRL_FLAG_BIT]) flag_q <= 1'b0;
         end
         if (done && ovf) flag_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (bus_addr)
         RG_DIVISOR:               bus_rdata = divisor_q;
         RG_DVD_SHORT, RG_DVD_LOW: bus_rdata = dvd_lo_q;
         RG_DVD_HIGH:              bus_rdata = dvd_hi_q;
         RG_CTRL:                  bus_rdata = {{(DW-2){1'b0}}, en_q, flag_q};
         RG_VECTOR:                bus_rdata = {{(DW-VEC_W){1'b0}}, vec_q};
         default:                  bus_rdata = '0;
      endcase
   end

   assign irq        = flag_q & en_q;
   assign irq_vector = vec_q;

   // R2: a full-width short write fills the high word with the sign bit
   a_r2_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_ok && hit_short && !bus_half) |=> (dvd_hi_q == {DW{$past(bus_wdata[DW-1])}}));
   // R4: divisor writes while busy are dropped
   a_r4_divisor_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && busy && hit_div) |=> $stable(divisor_q));
   // R5: overflow completion sets the flag
   a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ovf) |=> flag_q);
   // R6: a clear with no simultaneous overflow drops the request
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && hit_ctrl && !bus_wdata[CTRL_FLAG_BIT] && !(done && ovf)) |=> !irq);
   // R7: vector changes only by a write to its index
   a_r7_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_any && hit_vec) |=> $stable(irq_vector));

endmodule

// File: tb/sdiv_unit_bench.sv
`timescale 1ns/1ps
module sdiv_unit_bench;

   localparam logic [2:0] A_DIV = 3'd0, A_SHORT = 3'd1, A_CTRL = 3'd2,
                          A_VEC = 3'd3, A_HIGH  = 3'd4, A_LOW  = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_half = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        busy, irq;
   logic [6:0]  irq_vector;

   always #2.5 clk = ~clk;

   sdiv_unit u_sdiv_unit (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .busy(busy), .irq(irq), .irq_vector(irq_vector)
   );

   // reference model state
   logic [31:0] m_dvs, m_hi, m_lo;
   logic        m_flag = 1'b0, m_en = 1'b0, m_just = 1'b0;
   logic [6:0]  m_vec;
   bit          m_vec_ok = 1'b0;
   int          m_cnt = 0;
   logic [31:0] p_q, p_r;
   logic        p_ov;
   int          n_chk = 0, n_fail = 0, obs_busy = 0;
   bit          finished = 1'b0;
   logic [31:0] rs = 32'h1234_5679;

   function automatic void chk(input bit ok, input string req,
                               input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endfunction

   function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic h);
      return h ? {o[31:16], n[15:0]} : n;
   endfunction

   function automatic void calc(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] d,
                                output logic [31:0] q, output logic [31:0] r, output logic ov);
      logic signed [127:0] a, b, qq, rr;
      bit neg;
      a   = {{64{hi[31]}}, hi, lo};
      b   = {{96{d[31]}}, d};
      neg = hi[31] ^ d[31];
      r   = hi;
      if (d == 32'd0) begin
         ov = 1'b1;
      end else begin
         qq = a / b;
         rr = a % b;
         ov = (qq > 128'sh7FFF_FFFF) || (qq < -128'sh8000_0000);
         q  = qq[31:0];
         r  = rr[31:0];
      end
      if (ov) q = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
   endfunction

   task automatic model_tick();
      m_just = 1'b0;
      if (m_cnt > 0) begin
         m_cnt--;
         if (m_cnt == 0) begin
            m_lo = p_q;
            if (!p_ov) m_hi = p_r;
            else begin m_flag = 1'b1; m_just = 1'b1; end
         end
      end
   endtask

   task automatic model_write(input logic [2:0] a, input logic [31:0] d, input logic h, input bit bb);
      case (a)
         A_DIV:   if (!bb) m_dvs = mrg(m_dvs, d, h);
         A_HIGH:  if (!bb) m_hi = mrg(m_hi, d, h);
         A_LOW, A_SHORT: if (!bb) begin
            m_lo = mrg(m_lo, d, h);
            if (a == A_SHORT) m_hi = {32{m_lo[31]}};
            calc(m_hi, m_lo, m_dvs, p_q, p_r, p_ov);
            m_cnt = 33;
         end
         A_CTRL: begin
            m_en = d[1];
            if (!d[0] && !m_just) m_flag = 1'b0;
         end
         A_VEC: begin m_vec = d[6:0]; m_vec_ok = 1'b1; end
         default: ;
      endcase
   endtask

   task automatic cmp_cycle();
      if (busy) obs_busy++;
      chk(busy === (m_cnt > 0), "R3 busy", {31'd0, busy}, {31'd0, m_cnt > 0});
      chk(irq === (m_flag & m_en), "R6 irq", {31'd0, irq}, {31'd0, m_flag & m_en});
      if (m_vec_ok) chk(irq_vector === m_vec, "R7 irq_vector", {25'd0, irq_vector}, {25'd0, m_vec});
   endtask

   task automatic idle();
      @(posedge clk); #1;
      model_tick();
      @(negedge clk);
      cmp_cycle();
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic h);
      bit bb;
      bb = (m_cnt > 0);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_half = h;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_half = 1'b0;
      model_tick();
      model_write(a, d, h, bb);
      @(negedge clk);
      cmp_cycle();
   endtask

   task automatic rd_chk(input logic [2:0] a, input string req);
      logic [31:0] e;
      case (a)
         A_DIV:          e = m_dvs;
         A_SHORT, A_LOW: e = m_lo;
         A_HIGH:         e = m_hi;
         A_CTRL:         e = {30'd0, m_en, m_flag};
         A_VEC:          e = {25'd0, m_vec};
         default:        e = 32'd0;
      endcase
      bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
      #1;
      chk(bus_rdata === e, req, bus_rdata, e);
      bus_sel = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 100 && m_cnt > 0; i++) idle();
   endtask

   // full 64/32 operation followed by result reads
   task automatic op64(input logic [31:0] d, input logic [31:0] hi, input logic [31:0] lo, input string req);
      wr(A_DIV, d, 1'b0);
      wr(A_HIGH, hi, 1'b0);
      obs_busy = 0;
      wr(A_LOW, lo, 1'b0);
      wait_idle();
      idle();
      chk(obs_busy == 33, "R3 busy length", obs_busy, 33);
      rd_chk(A_LOW, req);
      rd_chk(A_HIGH, req);
   endtask

   task automatic op32(input logic [31:0] d, input logic [31:0] v, input string req);
      wr(A_DIV, d, 1'b0);
      wr(A_SHORT, v, 1'b0);
      wait_idle();
      rd_chk(A_SHORT, req);
      rd_chk(A_HIGH, req);
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x;
      x = s ^ (s << 13);
      x = x ^ (x >> 17);
      return x ^ (x << 5);
   endfunction

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R9 busy in reset", {31'd0, busy}, 0);
      chk(irq === 1'b0, "R9 irq in reset", {31'd0, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk(A_CTRL, "R9 ctrl after reset");

      // R7: vector keeps 7 bits only
      wr(A_VEC, 32'hFFFF_FFA5, 1'b0);
      rd_chk(A_VEC, "R7 vector readback");

      // R1: sign combinations, truncation toward zero
      op64(32'd7, 32'd0, 32'd100, "R1 +100/+7");
      op64(32'd7, 32'hFFFF_FFFF, 32'hFFFF_FF9C, "R1 -100/+7");
      op64(32'hFFFF_FFF9, 32'd0, 32'd100, "R1 +100/-7");
      op64(32'hFFFF_FFF9, 32'hFFFF_FFFF, 32'hFFFF_FF9C, "R1 -100/-7");
      op64(32'h0000_0010, 32'h0000_0005, 32'h0000_0003, "R1 wide dividend");
      // quotient exactly -2^31 fits
      op64(32'd3, 32'hFFFF_FFFE, 32'h8000_0000, "R1 quotient at negative limit");

      // R2: short dividend
      op32(32'd7, 32'hFFFF_FF9C, "R2 short -100/7");
      op32(32'd0, 32'h8000_0000, "R2 sign fill negative");
      op32(32'd0, 32'h0000_1234, "R2 sign fill positive");

      // R6 with R5: enable interrupts, overflow raises irq
      wr(A_CTRL, 32'h0000_0002, 1'b0);
      op64(32'd3, 32'h0000_0001, 32'h8000_0000, "R5 quotient +2^31 saturates");
      chk(irq === 1'b1, "R6 irq after overflow", {31'd0, irq}, 1);
      chk(irq_vector === 7'h25, "R7 vector with irq", {25'd0, irq_vector}, 32'h25);
      wr(A_CTRL, 32'h0000_0003, 1'b0);
      rd_chk(A_CTRL, "R6 writing 1 keeps flag");
      wr(A_CTRL, 32'h0000_0002, 1'b0);
      rd_chk(A_CTRL, "R6 writing 0 clears flag");
      op64(32'd0, 32'hFFFF_FFF0, 32'd5, "R5 divide by zero");
      op64(32'd2, 32'h0000_0004, 32'd0, "R5 high word above divisor");
      op64(32'hFFFF_FFFF, 32'h8000_0000, 32'd0, "R5 most negative dividend");
      wr(A_CTRL, 32'h0000_0001, 1'b0);
      rd_chk(A_CTRL, "R6 enable off keeps flag");
      wr(A_CTRL, 32'h0000_0000, 1'b0);

      // R3/R4: activity during busy
      wr(A_DIV, 32'd7, 1'b0);
      wr(A_HIGH, 32'd0, 1'b0);
      wr(A_LOW, 32'd100, 1'b0);
      idle(); idle();
      rd_chk(A_LOW, "R3 read during busy");
      rd_chk(A_HIGH, "R3 read high during busy");
      wr(A_DIV, 32'd55, 1'b0);
      wr(A_HIGH, 32'hDEAD_BEEF, 1'b0);
      wr(A_SHORT, 32'd5, 1'b0);
      wr(A_LOW, 32'd9, 1'b0);
      rd_chk(A_DIV, "R4 divisor write ignored");
      wait_idle();
      rd_chk(A_LOW, "R4 quotient unaffected");
      rd_chk(A_HIGH, "R4 remainder unaffected");
      chk(busy === 1'b0, "R4 no restart", {31'd0, busy}, 0);

      // R8: 16-bit writes
      wr(A_HIGH, 32'hAAAA_5555, 1'b0);
      wr(A_HIGH, 32'hFFFF_1234, 1'b1);
      rd_chk(A_HIGH, "R8 half write high");
      wr(A_DIV, 32'h0001_0000, 1'b0);
      wr(A_DIV, 32'hFFFF_0003, 1'b1);
      rd_chk(A_DIV, "R8 half write divisor");
      wr(A_HIGH, 32'd0, 1'b0);
      wr(A_LOW, 32'h0000_0000, 1'b0);
      wait_idle();
      wr(A_LOW, 32'hFFFF_00FF, 1'b1);
      wait_idle();
      rd_chk(A_LOW, "R8 half write low starts op");

      // R7: vector survives reset
      @(negedge clk); rst_n = 1'b0;
      m_flag = 1'b0; m_en = 1'b0; m_cnt = 0;
      idle();
      rst_n = 1'b1;
      idle();
      rd_chk(A_VEC, "R7 vector kept over reset");
      rd_chk(A_CTRL, "R9 ctrl after second reset");

      // mixed operands
      for (int k = 0; k < 16; k++) begin
         logic [31:0] d, hi, lo;
         rs = nxt(rs); d  = rs;
         if (k % 3 == 0) d = {{20{d[31]}}, d[11:0]};
         rs = nxt(rs); hi = {{24{rs[31]}}, rs[7:0]};
         rs = nxt(rs); lo = rs;
         op64(d, hi, lo, "R1 mixed operands");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #750000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule